// File: doc/BRIEF.md
# Operand Forwarding Selector

This block resolves read-after-write dependencies for a five-stage, 16-bit in-order pipeline. It watches the three latches downstream of decode: decode/execute, execute/memory and memory/writeback. For the two execute-stage operands of the instruction in decode, it works out which source each operand must come from in the next cycle. It then registers a two-bit select code for each operand multiplexer, so the code travels into the decode/execute latch with the operands.

For the equality compare that decode performs on branches, the block returns the forwarded register values directly, in the same cycle. Those values can come from the live ALU output, the execute/memory latch, the memory/writeback latch or the register file.

A producer that is a load still in execute cannot supply its value in time. In that case the block raises a hazard flag and claims no forwarded value, so the surrounding control can insert a stall. When the enable input is low, forwarding is off: every select is register file, every compare value is the register-file value, and software is expected to pad hazards with nops.

Top module: `opnd_fwd_sel`

## Requirements
- R1: The execute select codes are registered and appear one clock after decode presents the sources. The code is 2'b01 when the matching producer sat in decode/execute, so the operand is taken from the execute/memory latch. It is 2'b10 when the producer sat in execute/memory, so the operand is taken from the memory/writeback latch.
- R2: When more than one latch holds the same destination, the youngest producer wins. For execute operands decode/execute beats execute/memory. For the compare the order is decode/execute, then execute/memory, then memory/writeback.
- R3: Register address 0 never matches. It yields select 2'b00 and the register-file value.
- R4: A latch takes part in matching only when its register-write flag is set. A matching latch without that flag is skipped, and an older writing latch is used instead.
- R5: If an execute source matches a load in decode/execute, load_use_o is 1 in that cycle. The registered select for that operand is then 2'b00.
- R6: Compare values are forwarded in the same cycle as follows: a decode/execute match returns alu_res_i, an execute/memory match returns xm_data_i, and a memory/writeback match returns mw_data_i. With no match, the register-file input is returned.
- R7: If a compare source's youngest match is a load in decode/execute or in execute/memory, cmp_hazard_o is 1 and that source returns its register-file value.
- R8: With fwd_en_i low, both selects become 2'b00 at the next edge, both compare outputs equal the register-file inputs, and both hazard flags are 0.
- R9: While rst_ni is low, both select outputs are 2'b00.
- R10: A select output never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fwd_en_i | input | 1 | Forwarding enable |
| ex_src0_addr_i | input | AW | First execute source register |
| ex_src1_addr_i | input | AW | Second execute source register |
| cmp_a_addr_i | input | AW | First compare source register |
| cmp_b_addr_i | input | AW | Second compare source register |
| cmp_a_rf_i | input | DW | Register-file value of first compare source |
| cmp_b_rf_i | input | DW | Register-file value of second compare source |
| dx_dst_i | input | AW | Destination in decode/execute latch |
| dx_wr_i | input | 1 | Decode/execute instruction writes a register |
| dx_ld_i | input | 1 | Decode/execute instruction is a load |
| xm_dst_i | input | AW | Destination in execute/memory latch |
| xm_wr_i | input | 1 | Execute/memory instruction writes a register |
| xm_ld_i | input | 1 | Execute/memory instruction is a load |
| xm_data_i | input | DW | Execute/memory latch result |
| mw_dst_i | input | AW | Destination in memory/writeback latch |
| mw_wr_i | input | 1 | Memory/writeback instruction writes a register |
| mw_data_i | input | DW | Memory/writeback latch value |
| alu_res_i | input | DW | Live ALU output of execute stage |
| ex_sel0_o | output | 2 | Registered select for first execute operand |
| ex_sel1_o | output | 2 | Registered select for second execute operand |
| cmp_a_o | output | DW | Forwarded first compare value |
| cmp_b_o | output | DW | Forwarded second compare value |
| load_use_o | output | 1 | Execute operand depends on a load in execute |
| cmp_hazard_o | output | 1 | Compare source depends on an unfinished load |

## Verification
The bench builds the block with its defaults: 16-bit data and 3-bit register addresses. With these values all eight registers are reachable, including address 0 and the top address 7, so the zero-register exclusion and the highest address are both exercised. Distinct 16-bit patterns are placed on the ALU, execute/memory, memory/writeback and register-file inputs. Because of this, every compare value identifies the exact source that supplied it, and a wrong priority or a wrong source is visible at the ports.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    SEL_RF   = 2'b00,
    SEL_NEAR = 2'b01,
    SEL_FAR  = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/fwd_hit.sv
module fwd_hit #(
  parameter int AW = 3
) (
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic          wr_i,
  output logic          hit_o
);
  localparam logic [AW-1:0] ZERO_REG = '0;
  // register 0 is hard-wired zero, never a forwarding target
  assign hit_o = wr_i && (src_i != ZERO_REG) && (src_i == dst_i);
endmodule

// File: rtl/fwd_ex_sel.sv
module fwd_ex_sel
  import fwd_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dx_dst_i,
  input  logic          dx_wr_i,
  input  logic          dx_ld_i,
  input  logic [AW-1:0] xm_dst_i,
  input  logic          xm_wr_i,
  output fwd_sel_e      sel_o,
  output logic          lu_o
);
  logic     hit_dx, hit_xm;
  fwd_sel_e sel_d, sel_q;

  fwd_hit #(.AW(AW)) u_hit_dx (.src_i(src_i), .dst_i(dx_dst_i), .wr_i(dx_wr_i), .hit_o(hit_dx));
  fwd_hit #(.AW(AW)) u_hit_xm (.src_i(src_i), .dst_i(xm_dst_i), .wr_i(xm_wr_i), .hit_o(hit_xm));

  always_comb begin
    sel_d = SEL_RF;
    lu_o  = 1'b0;
    if (en_i) begin
      if (hit_dx) begin
        if (dx_ld_i) lu_o  = 1'b1;   // load data not ready: claim nothing
        else         sel_d = SEL_NEAR;
      end else if (hit_xm) begin
        sel_d = SEL_FAR;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= SEL_RF;
    else         sel_q <= sel_d;
  end

  assign sel_o = sel_q;

  a_r1_near_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && hit_dx && !dx_ld_i) |=> (sel_q == SEL_NEAR));
  a_r2_young_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && hit_dx && hit_xm && !dx_ld_i) |=> (sel_q != SEL_FAR));
  a_r3_zero_reg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == '0) |=> (sel_q == SEL_RF));
  a_r5_lu_no_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lu_o |=> (sel_q == SEL_RF));
  a_r8_off_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (sel_q == SEL_RF));
  a_r10_sel_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_q != 2'b11);
endmodule

// File: rtl/fwd_cmp_sel.sv
module fwd_cmp_sel #(
  parameter int AW = 3,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [AW-1:0] src_i,
  input  logic [DW-1:0] rf_i,
  input  logic [AW-1:0] dx_dst_i,
  input  logic          dx_wr_i,
  input  logic          dx_ld_i,
  input  logic [DW-1:0] alu_res_i,
  input  logic [AW-1:0] xm_dst_i,
  input  logic          xm_wr_i,
  input  logic          xm_ld_i,
  input  logic [DW-1:0] xm_data_i,
  input  logic [AW-1:0] mw_dst_i,
  input  logic          mw_wr_i,
  input  logic [DW-1:0] mw_data_i,
  output logic [DW-1:0] val_o,
  output logic          hz_o
);
  logic hit_dx, hit_xm, hit_mw;

  fwd_hit #(.AW(AW)) u_hit_dx (.src_i(src_i), .dst_i(dx_dst_i), .wr_i(dx_wr_i), .hit_o(hit_dx));
  fwd_hit #(.AW(AW)) u_hit_xm (.src_i(src_i), .dst_i(xm_dst_i), .wr_i(xm_wr_i), .hit_o(hit_xm));
  fwd_hit #(.AW(AW)) u_hit_mw (.src_i(src_i), .dst_i(mw_dst_i), .wr_i(mw_wr_i), .hit_o(hit_mw));

  always_comb begin
    val_o = rf_i;
    hz_o  = 1'b0;
    if (en_i) begin
      if (hit_dx) begin
        if (dx_ld_i) hz_o  = 1'b1;
        else         val_o = alu_res_i;
      end else if (hit_xm) begin
        // load in memory stage: latch holds address, not data
        if (xm_ld_i) hz_o  = 1'b1;
        else         val_o = xm_data_i;
      end else if (hit_mw) begin
        val_o = mw_data_i;
      end
    end
  end

  a_r7_hz_rf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hz_o |-> (val_o == rf_i));
  a_r8_off_cmp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (val_o == rf_i && !hz_o));
  a_r4_no_writer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dx_wr_i && !xm_wr_i && !mw_wr_i) |-> (val_o == rf_i && !hz_o));
  a_r6_mw_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && hit_mw && !hit_dx && !hit_xm) |-> (val_o == mw_data_i));
endmodule

// File: rtl/opnd_fwd_sel.sv
module opnd_fwd_sel
  import fwd_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fwd_en_i,
  input  logic [AW-1:0] ex_src0_addr_i,
  input  logic [AW-1:0] ex_src1_addr_i,
  input  logic [AW-1:0] cmp_a_addr_i,
  input  logic [AW-1:0] cmp_b_addr_i,
  input  logic [DW-1:0] cmp_a_rf_i,
  input  logic [DW-1:0] cmp_b_rf_i,
  input  logic [AW-1:0] dx_dst_i,
  input  logic          dx_wr_i,
  input  logic          dx_ld_i,
  input  logic [AW-1:0] xm_dst_i,
  input  logic          xm_wr_i,
  input  logic          xm_ld_i,
  input  logic [DW-1:0] xm_data_i,
  input  logic [AW-1:0] mw_dst_i,
  input  logic          mw_wr_i,
  input  logic [DW-1:0] mw_data_i,
  input  logic [DW-1:0] alu_res_i,
  output logic [1:0]    ex_sel0_o,
  output logic [1:0]    ex_sel1_o,
  output logic [DW-1:0] cmp_a_o,
  output logic [DW-1:0] cmp_b_o,
  output logic          load_use_o,
  output logic          cmp_hazard_o
);
  localparam int N_EX  = 2;
  localparam int N_CMP = 2;

  logic [AW-1:0] ex_src  [N_EX];
  fwd_sel_e      ex_sel  [N_EX];
  logic [N_EX-1:0] ex_lu;

  logic [AW-1:0] cmp_src [N_CMP];
  logic [DW-1:0] cmp_rf  [N_CMP];
  logic [DW-1:0] cmp_val [N_CMP];
  logic [N_CMP-1:0] cmp_hz;

  assign ex_src[0]  = ex_src0_addr_i;
  assign ex_src[1]  = ex_src1_addr_i;
  assign cmp_src[0] = cmp_a_addr_i;
  assign cmp_src[1] = cmp_b_addr_i;
  assign cmp_rf[0]  = cmp_a_rf_i;
  assign cmp_rf[1]  = cmp_b_rf_i;

  for (genvar g = 0; g < N_EX; g++) begin : g_ex
    fwd_ex_sel #(.AW(AW)) u_ex (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(fwd_en_i), .src_i(ex_src[g]),
      .dx_dst_i(dx_dst_i), .dx_wr_i(dx_wr_i), .dx_ld_i(dx_ld_i),
      .xm_dst_i(xm_dst_i), .xm_wr_i(xm_wr_i),
      .sel_o(ex_sel[g]), .lu_o(ex_lu[g])
    );
  end

  for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
    fwd_cmp_sel #(.AW(AW), .DW(DW)) u_cmp (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(fwd_en_i), .src_i(cmp_src[g]), .rf_i(cmp_rf[g]),
      .dx_dst_i(dx_dst_i), .dx_wr_i(dx_wr_i), .dx_ld_i(dx_ld_i), .alu_res_i(alu_res_i),
      .xm_dst_i(xm_dst_i), .xm_wr_i(xm_wr_i), .xm_ld_i(xm_ld_i), .xm_data_i(xm_data_i),
      .mw_dst_i(mw_dst_i), .mw_wr_i(mw_wr_i), .mw_data_i(mw_data_i),
      .val_o(cmp_val[g]), .hz_o(cmp_hz[g])
    );
  end

  assign ex_sel0_o    = ex_sel[0];
  assign ex_sel1_o    = ex_sel[1];
  assign cmp_a_o      = cmp_val[0];
  assign cmp_b_o      = cmp_val[1];
  assign load_use_o   = |ex_lu;
  assign cmp_hazard_o = |cmp_hz;

  a_r9_reset_sel: assert property (@(posedge clk_i)
    !rst_ni |-> (ex_sel0_o == 2'b00 && ex_sel1_o == 2'b00));
  a_r8_off_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fwd_en_i |-> (!load_use_o && !cmp_hazard_o));
endmodule

// File: tb/opnd_fwd_sel_tb_top.sv
module opnd_fwd_sel_tb_top;
  localparam int AW = 3;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en;
  logic [AW-1:0] s0, s1, ca, cb, dxd, xmd, mwd;
  logic [DW-1:0] car, cbr, xmv, mwv, alu;
  logic          dxw, dxl, xmw, xml, mww;
  logic [1:0]    sel0, sel1;
  logic [DW-1:0] cao, cbo;
  logic          lu, chz;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  opnd_fwd_sel #(.AW(AW), .DW(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fwd_en_i(en),
    .ex_src0_addr_i(s0), .ex_src1_addr_i(s1),
    .cmp_a_addr_i(ca), .cmp_b_addr_i(cb), .cmp_a_rf_i(car), .cmp_b_rf_i(cbr),
    .dx_dst_i(dxd), .dx_wr_i(dxw), .dx_ld_i(dxl),
    .xm_dst_i(xmd), .xm_wr_i(xmw), .xm_ld_i(xml), .xm_data_i(xmv),
    .mw_dst_i(mwd), .mw_wr_i(mww), .mw_data_i(mwv), .alu_res_i(alu),
    .ex_sel0_o(sel0), .ex_sel1_o(sel1), .cmp_a_o(cao), .cmp_b_o(cbo),
    .load_use_o(lu), .cmp_hazard_o(chz)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    en = 1'b1; s0 = '0; s1 = '0; ca = '0; cb = '0;
    dxd = '0; xmd = '0; mwd = '0; dxw = 0; dxl = 0; xmw = 0; xml = 0; mww = 0;
    car = 16'h1111; cbr = 16'h2222; xmv = 16'hC0DE; mwv = 16'hBEEF; alu = 16'hA1A1;
  endtask

  // drive at negedge, let the select register capture, sample after edge
  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic t_reset();
    idle(); s0 = 3; dxd = 3; dxw = 1;
    @(posedge clk); #2;
    chk("R9 sel0 in reset", {14'd0, sel0}, 0);
    chk("R9 sel1 in reset", {14'd0, sel1}, 0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_exec_fwd();
    @(negedge clk); idle(); s0 = 3; dxd = 3; dxw = 1; s1 = 5; xmd = 5; xmw = 1;
    step();
    chk("R1 sel0 near", {14'd0, sel0}, 16'd1);
    chk("R1 sel1 far", {14'd0, sel1}, 16'd2);
    chk("R10 sel1 legal", {15'd0, sel1 == 2'b11}, 0);
    @(negedge clk); idle(); s0 = 7; s1 = 6; xmd = 7; xmw = 1;
    step();
    chk("R1 sel0 far addr7", {14'd0, sel0}, 16'd2);
    chk("R1 sel1 none", {14'd0, sel1}, 16'd0);
  endtask

  task automatic t_youngest();
    @(negedge clk); idle(); s0 = 4; dxd = 4; dxw = 1; xmd = 4; xmw = 1;
    ca = 2; dxd = 4; mwd = 2; mww = 1; cb = 4;
    #1;
    chk("R2 cmp b dx over xm", cbo, 16'hA1A1);
    chk("R6 cmp a from mw", cao, 16'hBEEF);
    step();
    chk("R2 sel0 youngest", {14'd0, sel0}, 16'd1);
    @(negedge clk); idle(); ca = 6; xmd = 6; xmw = 1; mwd = 6; mww = 1;
    #1;
    chk("R2 cmp a xm over mw", cao, 16'hC0DE);
    chk("R6 cmp b rf no match", cbo, 16'h2222);
  endtask

  task automatic t_zero();
    @(negedge clk); idle(); s0 = 0; s1 = 0; dxd = 0; dxw = 1; xmd = 0; xmw = 1;
    mwd = 0; mww = 1; car = 16'h0000;
    #1;
    chk("R3 cmp r0 not forwarded", cao, 16'h0000);
    step();
    chk("R3 sel0 r0", {14'd0, sel0}, 0);
    chk("R3 sel1 r0", {14'd0, sel1}, 0);
  endtask

  task automatic t_nowr();
    @(negedge clk); idle(); s0 = 6; dxd = 6; dxw = 0; xmd = 6; xmw = 1;
    ca = 6; mwd = 6; mww = 1; cb = 1; mwd = 6;
    #1;
    chk("R4 cmp skips non-writer", cao, 16'hC0DE);
    step();
    chk("R4 sel0 skips non-writer", {14'd0, sel0}, 16'd2);
    @(negedge clk); idle(); s1 = 2; dxd = 2; xmd = 2; ca = 2; mwd = 2;
    #1;
    chk("R4 cmp no writers", cao, 16'h1111);
    step();
    chk("R4 sel1 no writers", {14'd0, sel1}, 0);
  endtask

  task automatic t_load();
    @(negedge clk); idle(); s1 = 5; dxd = 5; dxw = 1; dxl = 1; xmd = 5; xmw = 1;
    #1;
    chk("R5 load_use raised", {15'd0, lu}, 1);
    step();
    chk("R5 sel1 rf on load", {14'd0, sel1}, 0);
    @(negedge clk); idle(); s0 = 5; xmd = 5; xmw = 1; xml = 1;
    #1;
    chk("R5 no flag load in mem", {15'd0, lu}, 0);
    step();
    chk("R5 sel0 far for load in mem", {14'd0, sel0}, 16'd2);
  endtask

  task automatic t_cmp_hz();
    @(negedge clk); idle(); ca = 3; dxd = 3; dxw = 1; dxl = 1;
    #1;
    chk("R7 hazard load in ex", {15'd0, chz}, 1);
    chk("R7 rf on hazard", cao, 16'h1111);
    @(negedge clk); idle(); cb = 4; xmd = 4; xmw = 1; xml = 1; mwd = 4; mww = 1;
    #1;
    chk("R7 hazard load in mem", {15'd0, chz}, 1);
    chk("R7 rf on mem hazard", cbo, 16'h2222);
    @(negedge clk); idle(); cb = 4; mwd = 4; mww = 1;
    #1;
    chk("R7 no hazard", {15'd0, chz}, 0);
  endtask

  task automatic t_off();
    @(negedge clk); idle(); s0 = 3; dxd = 3; dxw = 1; s1 = 5; xmd = 5; xmw = 1;
    step();
    @(negedge clk); en = 1'b0; ca = 3; cb = 5; dxl = 1;
    #1;
    chk("R8 cmp a rf when off", cao, 16'h1111);
    chk("R8 cmp b rf when off", cbo, 16'h2222);
    chk("R8 flags off", {14'd0, lu, chz}, 0);
    step();
    chk("R8 sel0 off", {14'd0, sel0}, 0);
    chk("R8 sel1 off", {14'd0, sel1}, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle();
    t_reset();
    t_exec_fwd();
    t_youngest();
    t_zero();
    t_nowr();
    t_load();
    t_cmp_hz();
    t_off();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule